// File: doc/BRIEF.md
# Byte-Lane Steering Unit for Loads and Stores

This block sits between a 32-bit core and a byte-addressable data memory whose port is one 32-bit word wide. On the load side it takes the low bits of the byte address, the access size, a signed/unsigned flag, a byte-order select and the word read from memory. From these it produces the addressed byte, halfword or word, right-justified and extended to 32 bits. On the store side it takes the register value and returns write data with the value already moved into the correct byte lanes, together with one write strobe per lane.

The byte-order select is sampled on every access. In big-endian order the lowest address holds the most significant byte of a word. In little-endian order it holds the least significant byte. The select therefore decides which lane each address offset uses, for both load extraction and strobe placement. An access whose address does not suit its size raises a misalign flag. Such an access produces no strobes and returns zero on the load side. By default the datapath is combinational. A parameter can add one registered output stage for timing.

Top module: `lane_steer_unit`

## Requirements
- R1: In big-endian order (`big_endian`=1), a word load returns the byte at offset 0 in bits 31:24 and the byte at offset 3 in bits 7:0. The word lane layout maps offset k to lane 3-k, where lane j is `mem_rdata[8j+7:8j]`. With bytes 1A, C8, B2, 46 at offsets 0..3, the result is 0x1AC8B246.
- R2: In little-endian order (`big_endian`=0), offset k maps to lane k, and the byte at offset 0 lands in bits 7:0 of a word load. The same four bytes at offsets 0..3 read as 0x46B2C81A.
- R3: A byte load returns the byte at the addressed offset. A halfword load assembles the bytes at offsets a and a+1, with the byte at the lower address most significant in big-endian order and least significant in little-endian order.
- R4: When `sign_ext`=1, byte and halfword loads copy the top bit of the loaded value into all higher result bits. When `sign_ext`=0, those bits are zero. Word loads ignore `sign_ext`.
- R5: Byte accesses are always aligned. A halfword needs `addr_off[0]`=0. A word needs `addr_off[1:0]`=0. `misalign` is 1 exactly when this rule fails, whether or not `store_en` is set.
- R6: While `misalign` is 1, `store_strobe` and `store_data` are 0 and `load_value` is 0.
- R7: An aligned store with `store_en`=1 places byte j (bits 8j+7:8j) of `store_value` into the lane of the address that holds significance j in the selected byte order. It raises exactly the strobes of the lanes written, and leaves all other lanes of `store_data` at zero.
- R8: With `store_en`=0, `store_strobe` and `store_data` are zero for any other inputs.
- R9: The size code is 00 for byte, 01 for halfword and 10 for word. Code 11 behaves exactly as word.
- R10: With the default `REG_OUT`=0, all outputs follow the inputs within the same cycle, and the reset input leaves them unaffected. With `REG_OUT`=1, outputs are registered and reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | 1 selects big-endian byte order, 0 little-endian |
| size_sel | input | 2 | Access size code: 00 byte, 01 halfword, 10/11 word |
| sign_ext | input | 1 | 1 sign-extends byte and halfword loads, 0 zero-extends |
| addr_off | input | OFF_W (2) | Low bits of the byte address (offset within the word) |
| store_en | input | 1 | Access is a store; enables strobes and write data |
| store_value | input | DATA_W (32) | Register value to be stored, right-justified |
| mem_rdata | input | DATA_W (32) | Word read from memory, lane j in bits 8j+7:8j |
| load_value | output | DATA_W (32) | Extracted and extended load result |
| store_data | output | DATA_W (32) | Store value steered into byte lanes |
| store_strobe | output | LANES (4) | Per-lane write enables |
| misalign | output | 1 | Access address does not suit its size |

## Verification
Every cycle, the embedded properties check the invariants that hold for any input. Misaligned and non-store accesses carry no strobes. The number of strobes equals the access size. Byte accesses never flag a misalign. Aligned word stores enable every lane. Unsigned byte loads have clear upper bits. Lane choice depends on byte order, so the exact placement of each byte is shown only by the bench's scenarios. These include the two word readings of the same bytes, every offset in both orders, sign-bit boundaries, the size-11 alias and a long random sweep against an address-ordered byte model.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE     = 2'b00,
    ACC_HALF     = 2'b01,
    ACC_WORD     = 2'b10,
    ACC_WORD_ALT = 2'b11
  } acc_size_e;

endpackage

// File: rtl/lane_geom.sv
module lane_geom
  import lane_steer_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] offset,
  input  acc_size_e        size,
  input  logic             big_endian,
  output logic [OFF_W-1:0] span_m1,
  output logic [OFF_W-1:0] low_lane,
  output logic [LANES-1:0] lane_mask,
  output logic             misalign
);

  localparam logic [OFF_W-1:0] TOP_LANE = OFF_W'(LANES - 1);

  always_comb begin
    unique case (size)
      ACC_BYTE: span_m1 = '0;
      ACC_HALF: span_m1 = OFF_W'(1);
      default:  span_m1 = TOP_LANE;
    endcase
  end

  // Alignment: the offset must be a multiple of the access width.
  assign misalign = (offset & span_m1) != '0;

  // Lane holding the least significant byte of the access.
  assign low_lane = big_endian ? (TOP_LANE - span_m1 - offset) : offset;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_mask
    assign lane_mask[gi] = (gi >= int'(low_lane)) &&
                           (gi <= int'(low_lane) + int'(span_m1));
  end

endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract #(
  parameter int LANES  = 4,
  parameter int OFF_W  = $clog2(LANES),
  parameter int DATA_W = 8 * LANES
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFF_W-1:0]  span_m1,
  input  logic [OFF_W-1:0]  low_lane,
  input  logic              sign_ext,
  input  logic              misalign,
  output logic [DATA_W-1:0] value
);

  localparam int SH_W = OFF_W + 3;

  logic [DATA_W-1:0] shifted;
  logic              fill;

  assign shifted = rdata >> {low_lane, 3'b000};
  assign fill    = sign_ext & shifted[SH_W'({span_m1, 3'b111})];

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign value[8*gi +: 8] = misalign ? 8'h00 :
                              (gi <= int'(span_m1)) ? shifted[8*gi +: 8] :
                              {8{fill}};
  end

endmodule

// File: rtl/lane_store_place.sv
module lane_store_place #(
  parameter int LANES  = 4,
  parameter int OFF_W  = $clog2(LANES),
  parameter int DATA_W = 8 * LANES
) (
  input  logic [DATA_W-1:0] value,
  input  logic [OFF_W-1:0]  span_m1,
  input  logic [OFF_W-1:0]  low_lane,
  input  logic [LANES-1:0]  lane_mask,
  input  logic              store_en,
  input  logic              misalign,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  strobe
);

  logic [DATA_W-1:0] trimmed;
  logic              active;

  assign active = store_en & ~misalign;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_trim
    assign trimmed[8*gi +: 8] = (gi <= int'(span_m1)) ? value[8*gi +: 8] : 8'h00;
  end

  assign wdata  = active ? (trimmed << {low_lane, 3'b000}) : '0;
  assign strobe = active ? lane_mask : '0;

endmodule

// File: rtl/lane_steer_unit.sv
module lane_steer_unit
  import lane_steer_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int REG_OUT = 0,
  parameter int OFF_W   = $clog2(LANES),
  parameter int DATA_W  = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian,
  input  logic [1:0]        size_sel,
  input  logic              sign_ext,
  input  logic [OFF_W-1:0]  addr_off,
  input  logic              store_en,
  input  logic [DATA_W-1:0] store_value,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] load_value,
  output logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  store_strobe,
  output logic              misalign
);

  acc_size_e         size;
  logic [OFF_W-1:0]  span_m1;
  logic [OFF_W-1:0]  low_lane;
  logic [LANES-1:0]  lane_mask;
  logic              mis_c;
  logic [DATA_W-1:0] load_c;
  logic [DATA_W-1:0] wdata_c;
  logic [LANES-1:0]  strobe_c;

  assign size = acc_size_e'(size_sel);

  lane_geom #(.LANES(LANES), .OFF_W(OFF_W)) u_geom (
    .offset     (addr_off),
    .size       (size),
    .big_endian (big_endian),
    .span_m1    (span_m1),
    .low_lane   (low_lane),
    .lane_mask  (lane_mask),
    .misalign   (mis_c)
  );

  lane_load_extract #(.LANES(LANES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_load (
    .rdata    (mem_rdata),
    .span_m1  (span_m1),
    .low_lane (low_lane),
    .sign_ext (sign_ext),
    .misalign (mis_c),
    .value    (load_c)
  );

  lane_store_place #(.LANES(LANES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .value     (store_value),
    .span_m1   (span_m1),
    .low_lane  (low_lane),
    .lane_mask (lane_mask),
    .store_en  (store_en),
    .misalign  (mis_c),
    .wdata     (wdata_c),
    .strobe    (strobe_c)
  );

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        load_value   <= '0;
        store_data   <= '0;
        store_strobe <= '0;
        misalign     <= 1'b0;
      end else begin
        load_value   <= load_c;
        store_data   <= wdata_c;
        store_strobe <= strobe_c;
        misalign     <= mis_c;
      end
    end
  end else begin : g_comb
    assign load_value   = load_c;
    assign store_data   = wdata_c;
    assign store_strobe = strobe_c;
    assign misalign     = mis_c;
  end

  AST_MIS_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    mis_c |-> (strobe_c == '0 && load_c == '0)); // R6

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !store_en |-> (strobe_c == '0 && wdata_c == '0)); // R8

  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (size_sel == 2'b00) |-> !mis_c); // R5

  AST_STROBE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (strobe_c != '0) |-> ($countones(strobe_c) ==
      ((size_sel == 2'b00) ? 1 : (size_sel == 2'b01) ? 2 : LANES))); // R7

  AST_WORD_FULL: assert property (@(posedge clk) disable iff (rst)
    (store_en && size_sel[1] && addr_off == '0) |-> (strobe_c == '1)); // R9

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (size_sel == 2'b00 && !sign_ext) |-> (load_c[DATA_W-1:8] == '0)); // R4

endmodule

// File: tb/lane_steer_unit_bench.sv
module lane_steer_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        sign_ext = 1'b0;
  logic [1:0]  addr_off = 2'b00;
  logic        store_en = 1'b0;
  logic [31:0] store_value = '0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] load_value;
  logic [31:0] store_data;
  logic [3:0]  store_strobe;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lane_steer_unit u_lane_steer_unit (
    .clk          (clk),
    .rst          (rst),
    .big_endian   (big_endian),
    .size_sel     (size_sel),
    .sign_ext     (sign_ext),
    .addr_off     (addr_off),
    .store_en     (store_en),
    .store_value  (store_value),
    .mem_rdata    (mem_rdata),
    .load_value   (load_value),
    .store_data   (store_data),
    .store_strobe (store_strobe),
    .misalign     (misalign)
  );

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: memory word viewed as bytes in address order.
  task automatic run(string tag, bit be, logic [1:0] sz, bit sx, int off,
                     bit st, logic [31:0] val, logic [31:0] rd);
    int          n;
    bit          mis;
    logic [7:0]  mb [4];
    logic [31:0] e_load, e_data;
    logic [3:0]  e_strb;
    @(negedge clk);
    big_endian = be; size_sel = sz; sign_ext = sx; addr_off = 2'(off);
    store_en = st; store_value = val; mem_rdata = rd;
    n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    mis = (off % n) != 0;
    for (int a = 0; a < 4; a++) mb[a] = be ? rd[8*(3-a) +: 8] : rd[8*a +: 8];
    e_load = '0; e_data = '0; e_strb = '0;
    for (int j = 0; j < n; j++) begin
      int a;
      int lane;
      a    = be ? off + n - 1 - j : off + j;
      lane = be ? 3 - a : a;
      e_load[8*j +: 8] = mb[a];
      if (st && !mis) begin
        e_data[8*lane +: 8] = val[8*j +: 8];
        e_strb[lane] = 1'b1;
      end
    end
    if (sx && n < 4 && e_load[8*n-1])
      for (int b = 8*n; b < 32; b++) e_load[b] = 1'b1;
    if (mis) e_load = '0;
    #1;
    check32(tag, "load_value", load_value, e_load);
    check32(tag, "store_data", store_data, e_data);
    check32(tag, "store_strobe", {28'd0, store_strobe}, {28'd0, e_strb});
    check32(tag, "misalign", {31'd0, misalign}, {31'd0, mis});
  endtask

  initial begin
    // R10: reset does not disturb the combinational outputs
    repeat (2) @(negedge clk);
    #1;
    check32("R10", "reset load_value", load_value, 32'h0);
    check32("R10", "reset strobe", {28'd0, store_strobe}, 32'h0);
    run("R10", 1'b1, 2'b10, 1'b0, 0, 1'b1, 32'hCAFE0001, 32'h01020304);
    @(negedge clk); rst = 1'b0;

    run("R1", 1'b1, 2'b10, 1'b0, 0, 1'b0, 32'h0, 32'h1AC8B246);
    check32("R1", "example word", load_value, 32'h1AC8B246);
    run("R2", 1'b0, 2'b10, 1'b0, 0, 1'b0, 32'h0, 32'h46B2C81A);
    check32("R2", "example word", load_value, 32'h46B2C81A);

    for (int o = 0; o < 4; o++) begin
      run("R3", 1'b1, 2'b00, 1'b0, o, 1'b0, 32'h0, 32'h11223344);
      run("R3", 1'b0, 2'b00, 1'b0, o, 1'b0, 32'h0, 32'h11223344);
    end
    run("R3", 1'b1, 2'b01, 1'b0, 2, 1'b0, 32'h0, 32'hA1B2C3D4);
    check32("R3", "BE half at 2", load_value, 32'h0000C3D4);
    run("R3", 1'b0, 2'b01, 1'b0, 2, 1'b0, 32'h0, 32'hA1B2C3D4);
    check32("R3", "LE half at 2", load_value, 32'h0000A1B2);

    run("R4", 1'b0, 2'b00, 1'b1, 1, 1'b0, 32'h0, 32'h00008000);
    run("R4", 1'b0, 2'b00, 1'b1, 1, 1'b0, 32'h0, 32'h00007F00);
    run("R4", 1'b1, 2'b01, 1'b1, 0, 1'b0, 32'h0, 32'h80010000);
    check32("R4", "signed half", load_value, 32'hFFFF8001);
    run("R4", 1'b1, 2'b10, 1'b1, 0, 1'b0, 32'h0, 32'h80000000);

    run("R5", 1'b0, 2'b01, 1'b0, 1, 1'b0, 32'h0, 32'hFFFFFFFF);
    run("R5", 1'b1, 2'b10, 1'b0, 2, 1'b0, 32'h0, 32'hFFFFFFFF);
    run("R6", 1'b0, 2'b01, 1'b0, 3, 1'b1, 32'h12345678, 32'hFFFFFFFF);
    run("R6", 1'b1, 2'b10, 1'b0, 1, 1'b1, 32'h12345678, 32'hFFFFFFFF);

    for (int o = 0; o < 4; o++) begin
      run("R7", 1'b1, 2'b00, 1'b0, o, 1'b1, 32'hDEADBEEF, 32'h0);
      run("R7", 1'b0, 2'b00, 1'b0, o, 1'b1, 32'hDEADBEEF, 32'h0);
    end
    run("R7", 1'b1, 2'b01, 1'b0, 0, 1'b1, 32'hDEADBEEF, 32'h0);
    check32("R7", "BE half store", store_data, 32'hBEEF0000);
    run("R7", 1'b0, 2'b10, 1'b0, 0, 1'b1, 32'hDEADBEEF, 32'h0);

    run("R8", 1'b1, 2'b00, 1'b0, 2, 1'b0, 32'hFFFFFFFF, 32'h0);
    run("R9", 1'b1, 2'b11, 1'b1, 0, 1'b1, 32'h87654321, 32'h89ABCDEF);
    run("R9", 1'b0, 2'b11, 1'b0, 2, 1'b1, 32'h87654321, 32'h89ABCDEF);

    for (int k = 0; k < 600; k++)
      run("R3_R4_R5_R7", 1'($urandom), 2'($urandom), 1'($urandom), int'($urandom % 4),
          1'($urandom), $urandom, $urandom);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule